// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block keeps the per-source state of an interrupt distributor and makes it reachable through a small memory-mapped register port. Each source has the following state:

- an enable bit and a pending bit;
- an active bit and a captured input level;
- two configuration bits: a model flag and an edge/level selector;
- a priority byte and a target byte.

The external interrupt lines are captured here. Line k belongs to source ID k+32. A rising line records its level and pends the source. A falling line only clears the recorded level. All per-source state leaves the block as flat vectors, which feed a separate priority selector. The acknowledge/complete strobes from the CPU side move sources between pending and active.

Software reaches the state with byte, halfword or word accesses at a 12-bit offset:

- Enable and pending each have a set bank and a clear bank. In these banks a written 1 acts and a written 0 does nothing.
- A software-trigger word can pend any ID.
- Accesses that fall outside the map read zero, have no effect and raise an error flag with the response.

An access is handled by a three-state sequencer:

- `ST_IDLE` accepts a request.
- `ST_LANE` decodes one byte lane per cycle, lowest lane first, with a single shared byte decoder.
- `ST_RESP` presents the assembled read data and error flag for one cycle.

The transitions are:

- `ST_IDLE` to `ST_LANE` on an aligned request that is not a software trigger.
- `ST_IDLE` to `ST_RESP` on a software trigger or a misaligned request.
- `ST_LANE` to `ST_LANE` while lanes remain.
- `ST_LANE` to `ST_RESP` after the last lane.
- `ST_RESP` to `ST_IDLE` unconditionally.

Top module: `irqd_regbank`

## Requirements
- R1: After reset, IDs 0 to 14 are enabled and edge-triggered, and every other per-source bit is clear. All priority and target bytes are zero, the distributor enable is 0, and a read of offset 0x004 returns NUM_SRC/32-1.
- R2: Input line k drives ID k+32. A rise (line high while the recorded level is low) records the level and sets pending if the source is edge-triggered or enabled. A fall only clears the recorded level. An unchanged line does nothing.
- R3: Writing a 1 in the set-enable bank (0x100) sets that source's enable, and a 1 in the clear-enable bank (0x180) clears it. A 0 has no effect. Bit b of the byte at base+n stands for ID 8n+b, and both banks read back the enable bits.
- R4: Setting the enable of a level-triggered source whose recorded level is high also sets its pending bit.
- R5: A 1 written to set-pending (0x200) or clear-pending (0x280) sets or clears pending, and a 0 has no effect. Both banks read the pending bits with the layout of R3.
- R6: The active bank (0x300, layout of R3) is read-only. An acknowledge strobe for an ID sets its active bit and clears its pending bit. A completion strobe clears the active bit and re-pends the source if it is level-triggered, enabled and its level is high.
- R7: The priority byte of ID i is at 0x400+i and its target byte at 0x800+i. Both are exported on `src_prio` and `src_target`.
- R8: The configuration byte at 0xC00+n covers IDs 4n to 4n+3. For ID i, bit 2*(i%4) is the model flag and bit 2*(i%4)+1 selects edge triggering.
- R9: A halfword or word write to 0xF00 pends the ID in data bits 9:0. An ID of NUM_SRC or more changes nothing and reports an error.
- R10: Bit 0 of offset 0x000 is the distributor enable, exported on `dist_enable`. Writes to offsets 0x001 to 0x007 are ignored without error, and those offsets other than 0x004 read zero.
- R11: A byte lane at an unmapped offset, at an ID at or beyond NUM_SRC, or a write to the active bank reads zero and changes nothing, and `resp_err` is raised with the response. A misaligned access, or size code 3, changes nothing and also reports an error.
- R12: A request is taken only while `req_ready` is high. Multi-byte data is little-endian (byte k at offset+k). `resp_valid` is a single-cycle pulse that ends each access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | NUM_SRC-32 | External interrupt lines, line k is ID k+32 |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Sequencer idle, request taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | 12 | Byte offset |
| req_wdata | input | 32 | Write data, little-endian |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_err | output | 1 | Error flag, valid with resp_valid |
| resp_rdata | output | 32 | Read data, valid with resp_valid |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_id | input | 10 | Acknowledged ID |
| done_valid | input | 1 | Completion strobe |
| done_id | input | 10 | Completed ID |
| dist_enable | output | 1 | Distributor enable |
| src_enable | output | NUM_SRC | Per-source enable |
| src_pending | output | NUM_SRC | Per-source pending |
| src_active | output | NUM_SRC | Per-source active |
| src_prio | output | NUM_SRC x 8 | Per-source priority |
| src_target | output | NUM_SRC x 8 | Per-source target |

## Verification
The assertions rely on a few assumptions about the stimulus:

- No acknowledge strobe arrives in the cycle that an edge-rise check observes.
- An input line that is high during reset is seen as a rise only on a cycle after reset.
- A request is never issued while `req_ready` is low.

The directed bench keeps within these limits. It issues one access at a time, drives the acknowledge and completion strobes only between accesses, and changes input lines only while the sequencer is idle. The enable-stability property assumes that enables change only through decoded lanes, so the bench never expects an enable change from the software-trigger path or from a line.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    localparam int ID_W = 10;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LANE,
        ST_RESP
    } acc_state_e;

    typedef enum logic [3:0] {
        K_BAD,
        K_CTRL,
        K_TYPE,
        K_ZERO,
        K_SETEN,
        K_CLREN,
        K_SETPD,
        K_CLRPD,
        K_ACT,
        K_PRIO,
        K_TGT,
        K_CFG
    } lane_kind_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

endpackage

// File: rtl/irqd_lane_dec.sv
module irqd_lane_dec
    import irqd_pkg::*;
#(
    parameter int NUM_SRC = 96,
    localparam int IW = $clog2(NUM_SRC)
) (
    input  logic [11:0]   addr,
    input  logic          write,
    output lane_kind_e    kind,
    output logic [IW-1:0] idx,
    output logic          err
);

    logic [11:0] raw;
    logic        grouped;

    always_comb begin
        kind    = K_BAD;
        raw     = 12'd0;
        grouped = 1'b0;
        if (addr < 12'h100) begin
            if (addr == 12'h000)     kind = K_CTRL;
            else if (addr == 12'h004) kind = K_TYPE;
            else if (addr < 12'h008)  kind = K_ZERO;
        end else if (addr < 12'h180) begin
            kind = K_SETEN; raw = (addr - 12'h100) << 3; grouped = 1'b1;
        end else if (addr < 12'h200) begin
            kind = K_CLREN; raw = (addr - 12'h180) << 3; grouped = 1'b1;
        end else if (addr < 12'h280) begin
            kind = K_SETPD; raw = (addr - 12'h200) << 3; grouped = 1'b1;
        end else if (addr < 12'h300) begin
            kind = K_CLRPD; raw = (addr - 12'h280) << 3; grouped = 1'b1;
        end else if (addr < 12'h380) begin
            kind = K_ACT;   raw = (addr - 12'h300) << 3; grouped = 1'b1;
        end else if (addr < 12'h400) begin
            kind = K_BAD;
        end else if (addr < 12'h800) begin
            kind = K_PRIO;  raw = addr - 12'h400; grouped = 1'b1;
        end else if (addr < 12'hC00) begin
            kind = K_TGT;   raw = addr - 12'h800; grouped = 1'b1;
        end else if (addr < 12'hF00) begin
            kind = K_CFG;   raw = (addr - 12'hC00) << 2; grouped = 1'b1;
        end
        if (grouped && (raw >= 12'(NUM_SRC))) kind = K_BAD;
        if (write && (kind == K_ACT))         kind = K_BAD;
    end

    assign idx = raw[IW-1:0];
    assign err = (kind == K_BAD);

endmodule

// File: rtl/irqd_src_cell.sv
module irqd_src_cell #(
    parameter bit RST_EDGE = 1'b0,
    parameter bit IS_EXT   = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line,
    input  logic       set_en,
    input  logic       clr_en,
    input  logic       set_pd,
    input  logic       clr_pd,
    input  logic       cfg_we,
    input  logic       cfg_model,
    input  logic       cfg_trig,
    input  logic       prio_we,
    input  logic       tgt_we,
    input  logic [7:0] wbyte,
    input  logic       ack,
    input  logic       done,
    output logic       en,
    output logic       pd,
    output logic       act,
    output logic       lvl,
    output logic       model,
    output logic       trig,
    output logic [7:0] prio,
    output logic [7:0] tgt
);

    logic rise;
    logic pd_nx;

    assign rise = IS_EXT && line && !lvl;

    always_comb begin
        pd_nx = pd;
        if (set_pd)                          pd_nx = 1'b1;
        if (clr_pd)                          pd_nx = 1'b0;
        if (rise && (trig || en))            pd_nx = 1'b1;
        if (set_en && lvl && !trig)          pd_nx = 1'b1;
        if (ack)                             pd_nx = 1'b0;
        if (done && !trig && en && lvl)      pd_nx = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en    <= RST_EDGE;
            trig  <= RST_EDGE;
            pd    <= 1'b0;
            act   <= 1'b0;
            lvl   <= 1'b0;
            model <= 1'b0;
            prio  <= 8'd0;
            tgt   <= 8'd0;
        end else begin
            if (IS_EXT) lvl <= line;
            en <= (en | set_en) & ~clr_en;
            pd <= pd_nx;
            if (ack)       act <= 1'b1;
            else if (done) act <= 1'b0;
            if (cfg_we) begin
                model <= cfg_model;
                trig  <= cfg_trig;
            end
            if (prio_we) prio <= wbyte;
            if (tgt_we)  tgt  <= wbyte;
        end
    end

endmodule

// File: rtl/irqd_regbank.sv
module irqd_regbank
    import irqd_pkg::*;
#(
    parameter int NUM_SRC        = 96,
    parameter int NUM_RESET_EDGE = 15,
    localparam int NUM_LINES     = NUM_SRC - 32,
    localparam int IW            = $clog2(NUM_SRC)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_LINES-1:0]      line_in,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic                      req_write,
    input  logic [1:0]                req_size,
    input  logic [11:0]               req_addr,
    input  logic [31:0]               req_wdata,
    output logic                      resp_valid,
    output logic                      resp_err,
    output logic [31:0]               resp_rdata,
    input  logic                      ack_valid,
    input  logic [ID_W-1:0]           ack_id,
    input  logic                      done_valid,
    input  logic [ID_W-1:0]           done_id,
    output logic                      dist_enable,
    output logic [NUM_SRC-1:0]        src_enable,
    output logic [NUM_SRC-1:0]        src_pending,
    output logic [NUM_SRC-1:0]        src_active,
    output logic [NUM_SRC-1:0][7:0]   src_prio,
    output logic [NUM_SRC-1:0][7:0]   src_target
);

    acc_state_e state, state_nx;

    logic        lat_write;
    logic [11:0] lat_addr;
    logic [31:0] lat_wdata;
    logic [1:0]  lane_cnt;
    logic [1:0]  last_lane;
    logic [31:0] rdata_acc;
    logic        err_acc;

    logic [11:0] cur_addr;
    logic [7:0]  cur_byte;
    lane_kind_e  dec_kind;
    logic [IW-1:0] dec_idx;
    logic        dec_err;
    logic        do_wr;
    logic [7:0]  lane_rd;

    logic        misaligned;
    logic        sgi_hit;
    logic        sgi_ok;
    logic        sgi_fire;
    logic [ID_W-1:0] sgi_id;

    logic [NUM_SRC-1:0] src_level;
    logic [NUM_SRC-1:0] src_model;
    logic [NUM_SRC-1:0] src_trig;

    // request classification in ST_IDLE
    always_comb begin
        unique case (req_size)
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = req_addr[0];
            SZ_WORD: misaligned = (req_addr[1:0] != 2'b00);
            default: misaligned = 1'b1;
        endcase
    end

    assign sgi_id   = req_wdata[ID_W-1:0];
    assign sgi_hit  = req_write && (req_size != SZ_BYTE) && !misaligned
                      && (req_addr == 12'hF00);
    assign sgi_ok   = (sgi_id < ID_W'(NUM_SRC));
    assign sgi_fire = (state == ST_IDLE) && req_valid && sgi_hit && sgi_ok;

    // current byte lane
    assign cur_addr = lat_addr + {10'd0, lane_cnt};
    assign cur_byte = lat_wdata[8*lane_cnt +: 8];

    irqd_lane_dec #(.NUM_SRC(NUM_SRC)) u_dec (
        .addr  (cur_addr),
        .write (lat_write),
        .kind  (dec_kind),
        .idx   (dec_idx),
        .err   (dec_err)
    );

    assign do_wr = (state == ST_LANE) && lat_write && !dec_err;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_nx = (sgi_hit || misaligned) ? ST_RESP : ST_LANE;
            ST_LANE: if (lane_cnt == last_lane) state_nx = ST_RESP;
            ST_RESP: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // sequencer datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_write   <= 1'b0;
            lat_addr    <= 12'd0;
            lat_wdata   <= 32'd0;
            lane_cnt    <= 2'd0;
            last_lane   <= 2'd0;
            rdata_acc   <= 32'd0;
            err_acc     <= 1'b0;
            dist_enable <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    lat_write <= req_write;
                    lat_addr  <= req_addr;
                    lat_wdata <= req_wdata;
                    lane_cnt  <= 2'd0;
                    last_lane <= (req_size == SZ_BYTE) ? 2'd0 :
                                 (req_size == SZ_HALF) ? 2'd1 : 2'd3;
                    rdata_acc <= 32'd0;
                    err_acc   <= misaligned || (sgi_hit && !sgi_ok);
                end
                ST_LANE: begin
                    rdata_acc[8*lane_cnt +: 8] <= lane_rd;
                    err_acc  <= err_acc | dec_err;
                    lane_cnt <= lane_cnt + 2'd1;
                    if (do_wr && (dec_kind == K_CTRL)) dist_enable <= cur_byte[0];
                end
                ST_RESP: ;
                default: ;
            endcase
        end
    end

    assign req_ready  = (state == ST_IDLE);
    assign resp_valid = (state == ST_RESP);
    assign resp_err   = (state == ST_RESP) && err_acc;
    assign resp_rdata = (state == ST_RESP) ? rdata_acc : 32'd0;

    // read data of the current lane
    always_comb begin
        lane_rd = 8'd0;
        unique case (dec_kind)
            K_CTRL:          lane_rd = {7'd0, dist_enable};
            K_TYPE:          lane_rd = 8'(NUM_SRC / 32 - 1);
            K_SETEN, K_CLREN: lane_rd = src_enable[dec_idx +: 8];
            K_SETPD, K_CLRPD: lane_rd = src_pending[dec_idx +: 8];
            K_ACT:           lane_rd = src_active[dec_idx +: 8];
            K_PRIO:          lane_rd = src_prio[dec_idx];
            K_TGT:           lane_rd = src_target[dec_idx];
            K_CFG: begin
                for (int j = 0; j < 4; j++) begin
                    lane_rd[2*j]   = src_model[int'(dec_idx) + j];
                    lane_rd[2*j+1] = src_trig[int'(dec_idx) + j];
                end
            end
            default:         lane_rd = 8'd0;
        endcase
    end

    // per-source cells
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        localparam int G8  = (g / 8) * 8;
        localparam int G4  = (g / 4) * 4;
        localparam int B8  = g % 8;
        localparam int B4  = g % 4;

        logic line_g;
        logic grp8_hit;
        logic grp4_hit;
        logic one_hit;

        if (g >= 32) begin : g_ext
            assign line_g = line_in[g-32];
        end else begin : g_int
            assign line_g = 1'b0;
        end

        assign grp8_hit = do_wr && (dec_idx == IW'(G8)) && cur_byte[B8];
        assign grp4_hit = do_wr && (dec_kind == K_CFG) && (dec_idx == IW'(G4));
        assign one_hit  = do_wr && (dec_idx == IW'(g));

        irqd_src_cell #(
            .RST_EDGE (g < NUM_RESET_EDGE),
            .IS_EXT   (g >= 32)
        ) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .line      (line_g),
            .set_en    (grp8_hit && (dec_kind == K_SETEN)),
            .clr_en    (grp8_hit && (dec_kind == K_CLREN)),
            .set_pd    ((grp8_hit && (dec_kind == K_SETPD)) ||
                        (sgi_fire && (sgi_id == ID_W'(g)))),
            .clr_pd    (grp8_hit && (dec_kind == K_CLRPD)),
            .cfg_we    (grp4_hit),
            .cfg_model (cur_byte[2*B4]),
            .cfg_trig  (cur_byte[2*B4+1]),
            .prio_we   (one_hit && (dec_kind == K_PRIO)),
            .tgt_we    (one_hit && (dec_kind == K_TGT)),
            .wbyte     (cur_byte),
            .ack       (ack_valid && (ack_id == ID_W'(g))),
            .done      (done_valid && (done_id == ID_W'(g))),
            .en        (src_enable[g]),
            .pd        (src_pending[g]),
            .act       (src_active[g]),
            .lvl       (src_level[g]),
            .model     (src_model[g]),
            .trig      (src_trig[g]),
            .prio      (src_prio[g]),
            .tgt       (src_target[g])
        );
    end

endmodule

// File: rtl/irqd_regbank_chk.sv
module irqd_regbank_chk #(
    parameter int NUM_SRC   = 96,
    localparam int NUM_LINES = NUM_SRC - 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic                 resp_valid,
    input logic                 resp_err,
    input logic                 ack_valid,
    input logic [NUM_LINES-1:0] line_in,
    input logic [NUM_SRC-1:0]   src_enable,
    input logic [NUM_SRC-1:0]   src_pending,
    input logic [NUM_SRC-1:0]   src_trig
);

    AST_ERR_WITH_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        resp_err |-> resp_valid); // R11

    AST_RESP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> (!resp_valid && req_ready)); // R12

    AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R12

    AST_ENABLE_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> $stable(src_enable)); // R3

    for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
        AST_EDGE_RISE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
            (line_in[k] && !$past(line_in[k]) && src_trig[k+32]
             && req_ready && !req_valid && !ack_valid)
            |=> src_pending[k+32]); // R2
    end

endmodule

bind irqd_regbank irqd_regbank_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .resp_valid  (resp_valid),
    .resp_err    (resp_err),
    .ack_valid   (ack_valid),
    .line_in     (line_in),
    .src_enable  (src_enable),
    .src_pending (src_pending),
    .src_trig    (src_trig)
);

// File: tb/irqd_regbank_bench.sv
module irqd_regbank_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_SRC    = 96;
    localparam int NUM_LINES  = NUM_SRC - 32;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [NUM_LINES-1:0]    line_in = '0;
    logic                    req_valid = 1'b0;
    logic                    req_ready;
    logic                    req_write = 1'b0;
    logic [1:0]              req_size = 2'd0;
    logic [11:0]             req_addr = 12'd0;
    logic [31:0]             req_wdata = 32'd0;
    logic                    resp_valid;
    logic                    resp_err;
    logic [31:0]             resp_rdata;
    logic                    ack_valid = 1'b0;
    logic [9:0]              ack_id = 10'd0;
    logic                    done_valid = 1'b0;
    logic [9:0]              done_id = 10'd0;
    logic                    dist_enable;
    logic [NUM_SRC-1:0]      src_enable;
    logic [NUM_SRC-1:0]      src_pending;
    logic [NUM_SRC-1:0]      src_active;
    logic [NUM_SRC-1:0][7:0] src_prio;
    logic [NUM_SRC-1:0][7:0] src_target;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irqd_regbank #(.NUM_SRC(NUM_SRC)) u_irqd_regbank (
        .clk (clk), .rst_n (rst_n), .line_in (line_in),
        .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
        .req_size (req_size), .req_addr (req_addr), .req_wdata (req_wdata),
        .resp_valid (resp_valid), .resp_err (resp_err), .resp_rdata (resp_rdata),
        .ack_valid (ack_valid), .ack_id (ack_id),
        .done_valid (done_valid), .done_id (done_id),
        .dist_enable (dist_enable), .src_enable (src_enable),
        .src_pending (src_pending), .src_active (src_active),
        .src_prio (src_prio), .src_target (src_target)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [1:0] sz, input logic [11:0] a,
                          input logic [31:0] wd, output logic [31:0] rd, output logic er);
        int waitc;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        waitc = 0;
        while (!resp_valid && waitc < 20) begin
            @(negedge clk);
            waitc++;
        end
        rd = resp_rdata;
        er = resp_err;
        if (!resp_valid) check("R12 response missing", 32'd0, 32'd1);
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] sz, input logic [11:0] a,
                          input logic [31:0] exp, input logic exp_err);
        logic [31:0] d; logic e;
        access(1'b0, sz, a, 32'd0, d, e);
        check(tag, d, exp);
        check({tag, " err"}, {31'd0, e}, {31'd0, exp_err});
    endtask

    task automatic wr_chk(input string tag, input logic [1:0] sz, input logic [11:0] a,
                          input logic [31:0] wd, input logic exp_err);
        logic [31:0] d; logic e;
        access(1'b1, sz, a, wd, d, e);
        check({tag, " err"}, {31'd0, e}, {31'd0, exp_err});
    endtask

    task automatic t_reset;
        check("R1 dist_enable", {31'd0, dist_enable}, 32'd0);
        check("R1 pending", 32'(src_pending[31:0]), 32'd0);
        rd_chk("R1 enables 0..31", 2'd2, 12'h100, 32'h0000_7FFF, 1'b0);
        rd_chk("R1 cfg 0..15", 2'd2, 12'hC00, 32'h2AAA_AAAA, 1'b0);
        rd_chk("R1 type word", 2'd2, 12'h004, 32'd2, 1'b0);
        rd_chk("R10 ctrl word", 2'd2, 12'h000, 32'd0, 1'b0);
    endtask

    task automatic t_enable;
        wr_chk("R3 set en", 2'd2, 12'h104, 32'h0000_0005, 1'b0);
        rd_chk("R3 en read", 2'd2, 12'h104, 32'h0000_0005, 1'b0);
        wr_chk("R3 clr en", 2'd2, 12'h184, 32'h0000_0001, 1'b0);
        rd_chk("R3 en after clr", 2'd2, 12'h184, 32'h0000_0004, 1'b0);
        wr_chk("R3 zero set", 2'd2, 12'h104, 32'h0, 1'b0);
        wr_chk("R3 zero clr", 2'd2, 12'h184, 32'h0, 1'b0);
        rd_chk("R3 zeros no effect", 2'd2, 12'h104, 32'h0000_0004, 1'b0);
    endtask

    task automatic t_edge;
        wr_chk("R8 cfg write", 2'd0, 12'hC08, 32'h08, 1'b0);
        rd_chk("R8 cfg read", 2'd0, 12'hC08, 32'h08, 1'b0);
        @(negedge clk); line_in[1] = 1'b1;
        repeat (2) @(negedge clk);
        check("R2 edge rise pends id33", {31'd0, src_pending[33]}, 32'd1);
        rd_chk("R2 pending bank", 2'd2, 12'h204, 32'h2, 1'b0);
        line_in[1] = 1'b0;
        repeat (2) @(negedge clk);
        rd_chk("R2 fall keeps pending", 2'd2, 12'h204, 32'h2, 1'b0);
    endtask

    task automatic t_level;
        @(negedge clk); line_in[3] = 1'b1;
        repeat (2) @(negedge clk);
        check("R2 level disabled no pend", {31'd0, src_pending[35]}, 32'd0);
        wr_chk("R4 enable high level", 2'd2, 12'h104, 32'h8, 1'b0);
        rd_chk("R4 pend on enable", 2'd2, 12'h204, 32'hA, 1'b0);
        rd_chk("R3 en 34,35", 2'd2, 12'h104, 32'hC, 1'b0);
    endtask

    task automatic t_pend;
        wr_chk("R5 clr pend", 2'd2, 12'h284, 32'h2, 1'b0);
        rd_chk("R5 after clr", 2'd2, 12'h284, 32'h8, 1'b0);
        wr_chk("R5 set pend", 2'd0, 12'h208, 32'h01, 1'b0);
        check("R5 id64 pending", {31'd0, src_pending[64]}, 32'd1);
        wr_chk("R5 zero clr", 2'd2, 12'h288, 32'h0, 1'b0);
        check("R5 zero no effect", {31'd0, src_pending[64]}, 32'd1);
    endtask

    task automatic t_sgi;
        wr_chk("R9 sgi id5", 2'd2, 12'hF00, 32'h0000_0005, 1'b0);
        rd_chk("R9 id5 pending", 2'd0, 12'h200, 32'h20, 1'b0);
        wr_chk("R9 sgi out of range", 2'd2, 12'hF00, 32'h0000_03FF, 1'b1);
        rd_chk("R9 no side effect", 2'd0, 12'h200, 32'h20, 1'b0);
    endtask

    task automatic t_bytes;
        wr_chk("R7 prio write", 2'd0, 12'h428, 32'hA5, 1'b0);
        rd_chk("R7 prio read", 2'd2, 12'h428, 32'h0000_00A5, 1'b0);
        check("R7 prio export", 32'(src_prio[40]), 32'hA5);
        wr_chk("R7 tgt half write", 2'd1, 12'h800, 32'h0000_BEEF, 1'b0);
        rd_chk("R12 tgt half read", 2'd1, 12'h800, 32'h0000_BEEF, 1'b0);
        rd_chk("R12 little endian byte", 2'd0, 12'h801, 32'hBE, 1'b0);
        check("R7 tgt export", 32'(src_target[0]), 32'hEF);
    endtask

    task automatic t_ctrl;
        wr_chk("R10 ctrl write", 2'd0, 12'h000, 32'h01, 1'b0);
        check("R10 dist_enable", {31'd0, dist_enable}, 32'd1);
        wr_chk("R10 ignored offset", 2'd0, 12'h002, 32'hFF, 1'b0);
        rd_chk("R10 ctrl readback", 2'd2, 12'h000, 32'h1, 1'b0);
    endtask

    task automatic t_errors;
        rd_chk("R11 unmapped read", 2'd2, 12'h380, 32'h0, 1'b1);
        wr_chk("R11 active write", 2'd2, 12'h300, 32'hFFFF_FFFF, 1'b1);
        rd_chk("R11 active unchanged", 2'd2, 12'h300, 32'h0, 1'b0);
        rd_chk("R11 id beyond range", 2'd2, 12'h10C, 32'h0, 1'b1);
        wr_chk("R11 misaligned", 2'd2, 12'h101, 32'hFFFF_FFFF, 1'b1);
        rd_chk("R11 misaligned no effect", 2'd2, 12'h100, 32'h0000_7FFF, 1'b0);
        rd_chk("R11 trigger read", 2'd2, 12'hF00, 32'h0, 1'b1);
        wr_chk("R11 size 3", 2'd3, 12'h100, 32'h0, 1'b1);
    endtask

    task automatic t_ack;
        @(negedge clk); ack_valid = 1'b1; ack_id = 10'd35;
        @(negedge clk); ack_valid = 1'b0;
        check("R6 ack clears pending", {31'd0, src_pending[35]}, 32'd0);
        check("R6 ack sets active", {31'd0, src_active[35]}, 32'd1);
        rd_chk("R6 active bank", 2'd2, 12'h304, 32'h8, 1'b0);
        @(negedge clk); done_valid = 1'b1; done_id = 10'd35;
        @(negedge clk); done_valid = 1'b0;
        check("R6 done clears active", {31'd0, src_active[35]}, 32'd0);
        check("R6 done re-pends level", {31'd0, src_pending[35]}, 32'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enable();
        t_edge();
        t_level();
        t_pend();
        t_sgi();
        t_bytes();
        t_ctrl();
        t_errors();
        t_ack();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule